// File: doc/BRIEF.md
# Power Partition Gating Controller

This block switches up to 32 power partitions on and off and controls the isolation clamps on their outputs. Software drives it through four 32-bit registers. The first accepts toggle commands. The second reports which partitions are powered. The third takes clamp-release requests as a per-partition mask. The fourth reports which partitions are still clamped.

A toggle command names one partition and inverts its power state. While the command is in flight its busy bit reads 1. The busy bit clears by itself when the power switch reports completion. The switch is modelled as a fixed latency of `SWITCH_LAT` cycles. That latency is far shorter than the roughly 100 microsecond polling window software allows.

Clamps stay on after a partition powers up. They come off only through an explicit release request, and only for a partition that is powered. When a partition powers down, its clamp goes back on in the same cycle.

Top module: `ppg_ctrl`

## Requirements
- R1: After reset, every partition is unpowered and every partition is clamped: the clamp status reads all ones. The busy bit and every clamp command bit read 0.
- R2: A write to offset 0x030 with bit 8 set starts a toggle of the partition whose ID is in bits [4:0]. Bit 8 of 0x030 then reads 1 for exactly `SWITCH_LAT` cycles. In the cycle it clears, the partition's power state inverts. Bits [4:0] of 0x030 read back the ID of the last accepted toggle.
- R3: Offset 0x038 reads 1 in bit n when partition n is powered. Two toggles of the same partition return it to unpowered.
- R4: A write to 0x030 with bit 8 clear starts nothing. It changes neither the busy bit, the readback ID nor any power state.
- R5: A toggle write that arrives while the busy bit is 1 is ignored. The running operation keeps its partition, and the partition named in the ignored write keeps its power state.
- R6: Writing a mask to 0x034 requests clamp release for each set bit n. For a powered partition, bit n of 0x034 reads 1 for one cycle and then clears itself. In the cycle it clears, bit n of the clamp status at 0x02C goes to 0.
- R7: A clamp-release request for an unpowered partition is dropped. Its bit in 0x034 reads 0 from the cycle after the write, and its clamp status bit stays 1.
- R8: When a partition powers off, its clamp status bit returns to 1 in the same cycle its power bit clears.
- R9: The output `part_pwr_en` equals the power status. The output `part_iso` equals the clamp status.
- R10: Reads of any offset other than 0x02C, 0x030, 0x034 and 0x038 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, captured at the clock edge |
| reg_addr | input | 12 | Byte offset for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| part_pwr_en | output | NUM_PART | Power switch enable per partition |
| part_iso | output | NUM_PART | Output isolation clamp per partition, 1 = clamped |

## Verification
The hardest situation to reach is a second toggle write that lands while the first is still running. It shows whether the in-flight partition is held and the new request is dropped. The bench issues two toggle writes on consecutive cycles and reads the target ID and power mask both before and after completion. A second hard case is a release mask that mixes powered and unpowered partitions. The bench writes such a mask and reads the command register in the very next cycle. That shows the unpowered bit was never set, while the powered bits are still pending.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int DW    = 32;
    localparam int AW    = 12;
    localparam int ID_W  = 5;
    localparam int GO_BIT = 8;

    localparam logic [AW-1:0] OFS_CLAMP_STAT = 12'h02C;
    localparam logic [AW-1:0] OFS_TOGGLE     = 12'h030;
    localparam logic [AW-1:0] OFS_CLAMP_CMD  = 12'h034;
    localparam logic [AW-1:0] OFS_PWR_STAT   = 12'h038;

    typedef enum logic {SW_IDLE, SW_BUSY} sw_state_e;

    typedef struct packed {
        logic            go;
        logic [ID_W-1:0] id;
    } toggle_req_t;

    function automatic toggle_req_t decode_toggle(input logic wr,
                                                  input logic [AW-1:0] addr,
                                                  input logic [DW-1:0] wdata);
        toggle_req_t r;
        r.go = wr && (addr == OFS_TOGGLE) && wdata[GO_BIT];
        r.id = wdata[ID_W-1:0];
        return r;
    endfunction

    function automatic logic [DW-1:0] pack_toggle(input logic busy,
                                                  input logic [ID_W-1:0] id);
        logic [DW-1:0] v;
        v = '0;
        v[GO_BIT] = busy;
        v[ID_W-1:0] = id;
        return v;
    endfunction

endpackage

// File: rtl/ppg_switch.sv
module ppg_switch
    import ppg_pkg::*;
#(
    parameter int NP  = 32,
    parameter int LAT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  toggle_req_t       req,
    output logic              busy,
    output logic [ID_W-1:0]   target,
    output logic [NP-1:0]     pwr,
    output logic [NP-1:0]     going_off
);
    localparam int CW = $clog2(LAT + 1);

    sw_state_e          state_q;
    logic [CW-1:0]      cnt_q;
    logic [NP-1:0]      flip;
    logic               done;

    assign done      = (state_q == SW_BUSY) && (cnt_q == CW'(1));
    assign flip      = done ? (NP'(1) << target) : '0;
    assign going_off = flip & pwr;
    assign busy      = (state_q == SW_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            cnt_q   <= '0;
            target  <= '0;
            pwr     <= '0;
        end else begin
            case (state_q)
                SW_IDLE: begin
                    if (req.go && (int'(req.id) < NP)) begin
                        state_q <= SW_BUSY;
                        target  <= req.id;
                        cnt_q   <= CW'(LAT);
                    end
                end
                SW_BUSY: begin
                    if (done) begin
                        pwr     <= pwr ^ flip;
                        state_q <= SW_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ppg_clamp.sv
module ppg_clamp #(
    parameter int NP = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic [NP-1:0] cmd_mask,
    input  logic [NP-1:0] pwr,
    input  logic [NP-1:0] going_off,
    output logic [NP-1:0] cmd,
    output logic [NP-1:0] clamp
);
    logic [NP-1:0] release_now;
    logic [NP-1:0] eligible;

    assign eligible    = pwr & ~going_off;
    assign release_now = cmd & eligible;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd   <= '0;
            clamp <= '1;
        end else begin
            clamp <= (clamp & ~release_now) | going_off;
            cmd   <= cmd_wr ? (cmd_mask & eligible) : '0;
        end
    end
endmodule

// File: rtl/ppg_ctrl.sv
module ppg_ctrl
    import ppg_pkg::*;
#(
    parameter int NUM_PART   = 32,
    parameter int SWITCH_LAT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [11:0]         reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_PART-1:0] part_pwr_en,
    output logic [NUM_PART-1:0] part_iso
);
    toggle_req_t           tog_req;
    logic                  tog_busy;
    logic [ID_W-1:0]       tog_target;
    logic [NUM_PART-1:0]   pwr_state;
    logic [NUM_PART-1:0]   off_mask;
    logic [NUM_PART-1:0]   clamp_cmd;
    logic [NUM_PART-1:0]   clamp_state;
    logic                  clamp_wr;

    assign tog_req  = decode_toggle(reg_wr, reg_addr, reg_wdata);
    assign clamp_wr = reg_wr && (reg_addr == OFS_CLAMP_CMD);

    ppg_switch #(.NP(NUM_PART), .LAT(SWITCH_LAT)) u_switch (
        .clk       (clk),
        .rst       (rst),
        .req       (tog_req),
        .busy      (tog_busy),
        .target    (tog_target),
        .pwr       (pwr_state),
        .going_off (off_mask)
    );

    ppg_clamp #(.NP(NUM_PART)) u_clamp (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (clamp_wr),
        .cmd_mask  (reg_wdata[NUM_PART-1:0]),
        .pwr       (pwr_state),
        .going_off (off_mask),
        .cmd       (clamp_cmd),
        .clamp     (clamp_state)
    );

    always_comb begin
        case (reg_addr)
            OFS_CLAMP_STAT: reg_rdata = DW'(clamp_state);
            OFS_TOGGLE:     reg_rdata = pack_toggle(tog_busy, tog_target);
            OFS_CLAMP_CMD:  reg_rdata = DW'(clamp_cmd);
            OFS_PWR_STAT:   reg_rdata = DW'(pwr_state);
            default:        reg_rdata = '0;
        endcase
    end

    assign part_pwr_en = pwr_state;
    assign part_iso    = clamp_state;
endmodule

// File: rtl/ppg_chk.sv
module ppg_chk #(
    parameter int NP = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic [4:0]    tgt,
    input logic [NP-1:0] pwr,
    input logic [NP-1:0] iso,
    input logic [NP-1:0] cmd,
    input logic          cmd_wr
);
    // R8
    unpowered_clamped_chk: assert property (@(posedge clk) disable iff (rst)
        ((~pwr & ~iso) == '0));

    // R7
    cmd_needs_power_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd & ~pwr) == '0));

    // R2
    pwr_change_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr != $past(pwr)) |-> $fell(busy));

    // R2
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pwr ^ $past(pwr)));

    // R5
    busy_target_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(tgt));

    // R6
    cmd_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd != '0) && !cmd_wr) |=> (cmd == '0));
endmodule

bind ppg_ctrl ppg_chk #(.NP(NUM_PART)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (tog_busy),
    .tgt    (tog_target),
    .pwr    (pwr_state),
    .iso    (clamp_state),
    .cmd    (clamp_cmd),
    .cmd_wr (clamp_wr)
);

// File: tb/ppg_ctrl_bench.sv
`timescale 1ns/1ps
module ppg_ctrl_bench;
    localparam int NP  = 32;
    localparam int LAT = 4;

    typedef struct packed {
        bit          wr;
        logic [11:0] addr;
        logic [31:0] data;
        int          idle;
        int          req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 12'h030, 32'h0000_0105, 0, 2},  // R2 start toggle of partition 5
        '{1'b0, 12'h030, 32'h0000_0105, 0, 2},  // R2 busy set
        '{1'b0, 12'h038, 32'h0000_0000, 0, 2},  // R2 not yet powered
        '{1'b0, 12'h030, 32'h0000_0105, 3, 2},  // R2 busy in last cycle
        '{1'b0, 12'h030, 32'h0000_0005, 1, 2},  // R2 busy cleared
        '{1'b0, 12'h038, 32'h0000_0020, 0, 3},  // R3 partition 5 powered
        '{1'b0, 12'h02C, 32'hFFFF_FFFF, 0, 6},  // R6 clamp kept after power-up
        '{1'b1, 12'h030, 32'h0000_0002, 0, 4},  // R4 write without start
        '{1'b0, 12'h030, 32'h0000_0005, 0, 4},  // R4 no busy, id unchanged
        '{1'b0, 12'h038, 32'h0000_0020, 5, 4},  // R4 no power change
        '{1'b1, 12'h030, 32'h0000_0103, 0, 5},  // R5 toggle partition 3
        '{1'b1, 12'h030, 32'h0000_0107, 0, 5},  // R5 ignored while busy
        '{1'b0, 12'h030, 32'h0000_0103, 0, 5},  // R5 target held
        '{1'b0, 12'h038, 32'h0000_0020, 2, 5},  // R5 still in flight
        '{1'b0, 12'h038, 32'h0000_0028, 1, 3},  // R3 partition 3 on, 7 untouched
        '{1'b0, 12'h030, 32'h0000_0003, 0, 5},  // R5 finished target 3
        '{1'b1, 12'h034, 32'h0000_0029, 0, 6},  // R6 release 5,3 and unpowered 0
        '{1'b0, 12'h034, 32'h0000_0028, 0, 7},  // R7 bit 0 dropped at once
        '{1'b0, 12'h034, 32'h0000_0000, 1, 6},  // R6 command self-clears
        '{1'b0, 12'h02C, 32'hFFFF_FFD7, 0, 7},  // R7 clamp 0 stays, 3 and 5 released
        '{1'b1, 12'h030, 32'h0000_0105, 0, 8},  // R8 power off partition 5
        '{1'b0, 12'h02C, 32'hFFFF_FFD7, 3, 8},  // R8 still unclamped while busy
        '{1'b0, 12'h02C, 32'hFFFF_FFF7, 1, 8},  // R8 reclamped at power off
        '{1'b0, 12'h038, 32'h0000_0008, 0, 8},  // R8 power bit cleared
        '{1'b0, 12'h040, 32'h0000_0000, 0, 10}, // R10 unmapped offset
        '{1'b0, 12'h000, 32'h0000_0000, 0, 10}, // R10 unmapped offset
        '{1'b1, 12'h030, 32'h0000_0103, 0, 3},  // R3 second toggle of 3
        '{1'b0, 12'h038, 32'h0000_0000, 4, 3},  // R3 back to unpowered
        '{1'b0, 12'h02C, 32'hFFFF_FFFF, 0, 8}   // R8 all clamped again
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] part_pwr_en;
    logic [NP-1:0] part_iso;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ppg_ctrl #(.NUM_PART(NP), .SWITCH_LAT(LAT)) u_ppg_ctrl (
        .clk         (clk),
        .rst         (rst),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .part_pwr_en (part_pwr_en),
        .part_iso    (part_iso)
    );

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reset_checks();
        do_read(1, 12'h038, 32'h0);            // R1 unpowered
        do_read(1, 12'h02C, 32'hFFFF_FFFF);    // R1 clamped
        do_read(1, 12'h030, 32'h0);            // R1 not busy
        do_read(1, 12'h034, 32'h0);            // R1 no commands
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        reset_checks();

        for (int v = 0; v < NV; v++) begin
            idle(TABLE[v].idle);
            if (TABLE[v].wr) do_write(TABLE[v].addr, TABLE[v].data);
            else do_read(TABLE[v].req, TABLE[v].addr, TABLE[v].data);
        end

        // R9 ports follow status: power partition 0 and release its clamp
        do_write(12'h030, 32'h0000_0100);
        idle(LAT);
        do_write(12'h034, 32'h0000_0001);
        idle(1);
        #1;
        check(9, 32'(part_pwr_en), 32'h0000_0001);
        check(9, 32'(part_iso), 32'hFFFF_FFFE);
        do_read(9, 12'h038, 32'(part_pwr_en));

        // R1 reset from a busy, powered state
        do_write(12'h030, 32'h0000_011F);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        #1;
        check(1, 32'(part_pwr_en), 32'h0);
        check(1, 32'(part_iso), 32'hFFFF_FFFF);
        reset_checks();
        idle(LAT + 1);
        do_read(1, 12'h038, 32'h0);            // R1 aborted toggle has no effect

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule